// File: doc/BRIEF.md
# Low-Power Down-Counting Interval Timer

This block is a 16-bit down-counter for periodic interrupts and for counting external events. Software reaches it through a halfword-wide register bus with byte lanes. The bus gives access to the counter and its reload value, two compare values, a control byte and two mode bytes. After software starts it, the counter steps down once for each tick of the selected count source. When it steps past zero, it reloads from the last value written to the counter, raises a sticky underflow flag and pulses the interrupt output for one clock.

All count sources arrive as enable strobes on the single system clock:

- the system clock itself;
- the system clock divided by two or by eight, both made inside the block;
- a low-speed strobe and a subclock strobe, each through a power-of-two prescaler;
- the underflow pulse of a sibling timer.

In event-counter mode the counter steps on the selected edge of an external input instead. That input is first resynchronised through two flops.

Each sticky flag is cleared only by writing 0 to its bit. A forced-stop bit, which acts when written with 1, halts counting at once and reloads the counter.

Top module: `lp_down_timer`

## Requirements
- R1: After synchronous reset, every register reads as 0 and `irq_unf` is low.
- R2: Register slots are selected by `bus_sel`: 0 counter, 1 compare A, 2 compare B, 3 control byte in bits [7:0] with mode-1 byte in bits [15:8], 4 mode-2 byte in bits [7:0]. `bus_be[0]` enables bits [7:0] and `bus_be[1]` enables bits [15:8]. A read returns data on `bus_rdata` one clock after `bus_rd`. Mode-2 keeps only bits 7 (low-power select) and [2:0]; the other bits read 0.
- R3: Control bit 0 is the start bit and control bit 1 is the read-only count-status bit. The status bit becomes 1 within two clocks of start being written to 1. The counter changes only while the status bit is 1, except through a bus write or a forced stop.
- R4: On each tick the counter decrements. On a tick at value 0 it instead reloads the last value written to slot 0, sets the underflow flag (control bit 5) and drives `irq_unf` high for one clock. With reload value N and one tick per clock, the interval between interrupts is N+1 clocks.
- R5: Writing 1 to control bit 2 clears the start bit and the status bit and reloads the counter. It wins over a start written 1 in the same write.
- R6: The flags in control bits 4 to 7 are cleared only by writing 0 to them. Writing 1 leaves them unchanged.
- R7: The compare-A flag (bit 6) and the compare-B flag (bit 7) are set when the counter equals compare A or compare B on a counting tick.
- R8: Mode-1 bits [6:4] select the count source in timer mode: 000 every clock, 001 every 8th clock, 011 every 2nd clock, 101 each `chain_unf_in` strobe.
- R9: Source 100 (`lsclk_stb`) and source 110 (`subclk_stb`) tick once every 2^n strobes, where n is mode-2 bits [2:0].
- R10: In event mode (mode-1 bits [2:0] = 010), the counter decrements on the rising edge of `evt_in` when mode-1 bit 3 is 0 and on the falling edge when it is 1, after a two-flop synchroniser. Each counted edge sets the edge flag (control bit 4).
- R11: In the operating modes not built here (001, 011, 100 and the unused codes), the counter holds and no interrupt occurs, even while started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register slot select |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| lsclk_stb | input | 1 | Low-speed clock enable strobe |
| subclk_stb | input | 1 | Subclock enable strobe |
| chain_unf_in | input | 1 | Underflow strobe from the sibling timer |
| evt_in | input | 1 | Asynchronous external event input |
| irq_unf | output | 1 | One-clock underflow interrupt pulse |

## Verification
The assertions assume that a single bus access never combines a counter write with a forced stop. They also assume that strobe inputs are one-clock pulses aligned to the system clock. The directed stimulus issues one register access at a time and changes inputs only at the falling clock edge. The strobe generators raise each strobe for exactly one clock at a fixed spacing. `evt_in` is held for several clocks between changes, so every edge passes the synchroniser unambiguously.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SLOT_CNT   = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_CMPA  = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_CMPB  = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_CTRL  = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_MODE2 = 3'd4;

  localparam logic [2:0] OPM_TIMER = 3'b000;
  localparam logic [2:0] OPM_EVENT = 3'b010;

  localparam logic [2:0] SRC_PCLK   = 3'b000;
  localparam logic [2:0] SRC_PCLK8  = 3'b001;
  localparam logic [2:0] SRC_PCLK2  = 3'b011;
  localparam logic [2:0] SRC_LOWSPD = 3'b100;
  localparam logic [2:0] SRC_CHAIN  = 3'b101;
  localparam logic [2:0] SRC_SUB    = 3'b110;

  localparam int CKS_W = 3;

  typedef struct packed {
    logic [2:0] src;
    logic       pol;
    logic [2:0] opm;
  } mode1_t;

  typedef struct packed {
    logic             lpm;
    logic [CKS_W-1:0] cks;
  } mode2_t;

  // flag vector order: [0] edge, [1] underflow, [2] compare A, [3] compare B
  localparam int FLG_EDGE = 0;
  localparam int FLG_UNF  = 1;
  localparam int FLG_CMPA = 2;
  localparam int FLG_CMPB = 3;
endpackage

// File: rtl/lpt_edge_sync.sv
module lpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic            cur;
  logic            prv;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign cur    = sh_q[STAGES-1];
  assign prv    = sh_q[STAGES];
  assign edge_o = fall_sel ? (~cur & prv) : (cur & ~prv);
endmodule

// File: rtl/lpt_tick_sel.sv
module lpt_tick_sel
  import lpt_pkg::*;
#(
  parameter int PDIV_W = 3,
  parameter int PSC_W  = (1 << CKS_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       src,
  input  logic [CKS_W-1:0] cks,
  input  logic             lsclk_stb,
  input  logic             subclk_stb,
  input  logic             chain_unf,
  output logic             tick
);
  localparam int NSLOW = 2;

  logic [PDIV_W-1:0] pdiv_q;
  logic [NSLOW-1:0]  slow_stb;
  logic [NSLOW-1:0]  slow_tick;

  always_ff @(posedge clk) begin
    if (rst) pdiv_q <= '0;
    else     pdiv_q <= pdiv_q + 1'b1;
  end

  assign slow_stb = {subclk_stb, lsclk_stb};

  for (genvar g = 0; g < NSLOW; g++) begin : g_psc
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] mask;
    assign mask = ~({PSC_W{1'b1}} << cks);
    always_ff @(posedge clk) begin
      if (rst)              psc_q <= '0;
      else if (slow_stb[g]) psc_q <= psc_q + 1'b1;
    end
    assign slow_tick[g] = slow_stb[g] && ((psc_q & mask) == mask);
  end

  always_comb begin
    case (src)
      SRC_PCLK:   tick = 1'b1;
      SRC_PCLK8:  tick = &pdiv_q;
      SRC_PCLK2:  tick = pdiv_q[0];
      SRC_LOWSPD: tick = slow_tick[0];
      SRC_CHAIN:  tick = chain_unf;
      SRC_SUB:    tick = slow_tick[1];
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_en,
  input  logic [W/8-1:0] ld_be,
  input  logic [W-1:0]   ld_data,
  input  logic           reload_now,
  input  logic           run,
  input  logic           tick,
  input  logic [W-1:0]   cmp_a,
  input  logic [W-1:0]   cmp_b,
  output logic [W-1:0]   cnt_q,
  output logic [W-1:0]   reload_q,
  output logic           unf_q,
  output logic           hit_a_q,
  output logic           hit_b_q
);
  localparam int NB = W / 8;

  logic [W-1:0] merged;

  always_comb begin
    merged = reload_q;
    for (int b = 0; b < NB; b++) begin
      if (ld_be[b]) merged[b*8 +: 8] = ld_data[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      unf_q    <= 1'b0;
      hit_a_q  <= 1'b0;
      hit_b_q  <= 1'b0;
    end else begin
      unf_q   <= 1'b0;
      hit_a_q <= 1'b0;
      hit_b_q <= 1'b0;
      if (ld_en) reload_q <= merged;
      if (reload_now) begin
        cnt_q <= reload_q;
      end else if (ld_en) begin
        cnt_q <= merged;
      end else if (run && tick) begin
        hit_a_q <= (cnt_q == cmp_a);
        hit_b_q <= (cnt_q == cmp_b);
        if (cnt_q == '0) begin
          cnt_q <= reload_q;
          unf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lp_down_timer.sv
module lp_down_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [SLOT_W-1:0] bus_sel,
  input  logic [CNT_W/8-1:0] bus_be,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              lsclk_stb,
  input  logic              subclk_stb,
  input  logic              chain_unf_in,
  input  logic              evt_in,
  output logic              irq_unf
);
  localparam int BE_W = CNT_W / 8;

  logic [CNT_W-1:0] cmpa_q, cmpb_q, cnt_q, reload_q;
  mode1_t           mode1_q;
  mode2_t           mode2_q;
  logic             start_q, run_q;
  logic [3:0]       flags_q;
  logic             cnt_wr, ctrl_wr, mode1_wr, mode2_wr, stop_wr;
  logic             src_tick, evt_edge, cnt_tick;
  logic             unf_p, hit_a, hit_b, edge_seen_q;
  logic [7:0]       ctrl_byte;
  logic [3:0]       flag_keep, flag_set;

  assign cnt_wr   = bus_wr && (bus_sel == SLOT_CNT);
  assign ctrl_wr  = bus_wr && (bus_sel == SLOT_CTRL) && bus_be[0];
  assign mode1_wr = bus_wr && (bus_sel == SLOT_CTRL) && bus_be[BE_W-1];
  assign mode2_wr = bus_wr && (bus_sel == SLOT_MODE2) && bus_be[0];
  assign stop_wr  = ctrl_wr && bus_wdata[2];

  // compare registers with byte lanes
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < BE_W; b++) begin
        if (bus_be[b] && bus_sel == SLOT_CMPA) cmpa_q[b*8 +: 8] <= bus_wdata[b*8 +: 8];
        if (bus_be[b] && bus_sel == SLOT_CMPB) cmpb_q[b*8 +: 8] <= bus_wdata[b*8 +: 8];
      end
    end
  end

  // mode registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode1_q <= '0;
      mode2_q <= '0;
    end else begin
      if (mode1_wr) mode1_q <= mode1_t'(bus_wdata[CNT_W-2 -: 7]);
      if (mode2_wr) mode2_q <= '{lpm: bus_wdata[7], cks: bus_wdata[CKS_W-1:0]};
    end
  end

  // start / status
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (stop_wr)      start_q <= 1'b0;
      else if (ctrl_wr) start_q <= bus_wdata[0];
      run_q <= start_q && !stop_wr;
    end
  end

  lpt_tick_sel u_tick (
    .clk        (clk),
    .rst        (rst),
    .src        (mode1_q.src),
    .cks        (mode2_q.cks),
    .lsclk_stb  (lsclk_stb),
    .subclk_stb (subclk_stb),
    .chain_unf  (chain_unf_in),
    .tick       (src_tick)
  );

  lpt_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (evt_in),
    .fall_sel (mode1_q.pol),
    .edge_o   (evt_edge)
  );

  always_comb begin
    case (mode1_q.opm)
      OPM_TIMER: cnt_tick = src_tick;
      OPM_EVENT: cnt_tick = evt_edge;
      default:   cnt_tick = 1'b0;
    endcase
  end

  lpt_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ld_en      (cnt_wr),
    .ld_be      (bus_be),
    .ld_data    (bus_wdata),
    .reload_now (stop_wr),
    .run        (run_q),
    .tick       (cnt_tick),
    .cmp_a      (cmpa_q),
    .cmp_b      (cmpb_q),
    .cnt_q      (cnt_q),
    .reload_q   (reload_q),
    .unf_q      (unf_p),
    .hit_a_q    (hit_a),
    .hit_b_q    (hit_b)
  );

  always_ff @(posedge clk) begin
    if (rst) edge_seen_q <= 1'b0;
    else     edge_seen_q <= run_q && (mode1_q.opm == OPM_EVENT) && evt_edge && !cnt_wr && !stop_wr;
  end

  // sticky flags: set events win over a clearing write
  assign flag_keep = ctrl_wr ? bus_wdata[7:4] : 4'hF;
  assign flag_set  = {hit_b, hit_a, unf_p, edge_seen_q};

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & flag_keep) | flag_set;
  end

  assign irq_unf   = unf_p;
  assign ctrl_byte = {flags_q, 2'b00, run_q, start_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_sel)
        SLOT_CNT:   bus_rdata <= cnt_q;
        SLOT_CMPA:  bus_rdata <= cmpa_q;
        SLOT_CMPB:  bus_rdata <= cmpb_q;
        SLOT_CTRL:  bus_rdata <= CNT_W'({1'b0, mode1_q, ctrl_byte});
        SLOT_MODE2: bus_rdata <= CNT_W'({mode2_q.lpm, 4'b0000, mode2_q.cks});
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         irq,
  input logic         run_q,
  input logic         start_q,
  input logic         stop_wr,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] reload_q,
  input logic [3:0]   flags_q,
  input logic         hit_a
);
  // R4
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(run_q));

  // R5
  stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> (!start_q && !run_q));

  // R5
  stop_reload_chk: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> (cnt_q == reload_q));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_wr && !stop_wr) |=> $stable(cnt_q));

  // R6
  unf_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[1]) |-> $past(irq));

  // R7
  cmpa_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[2]) |-> $past(hit_a));
endmodule

bind lp_down_timer lpt_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq_unf),
  .run_q    (run_q),
  .start_q  (start_q),
  .stop_wr  (stop_wr),
  .cnt_wr   (cnt_wr),
  .cnt_q    (cnt_q),
  .reload_q (reload_q),
  .flags_q  (flags_q),
  .hit_a    (hit_a)
);

// File: tb/lp_down_timer_test.sv
module lp_down_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        lsclk_stb = 1'b0, subclk_stb = 1'b0, chain_unf_in = 1'b0, evt_in = 1'b0;
  logic        irq_unf;
  logic        ls_on = 1'b0, sub_on = 1'b0;
  int          n_chk = 0, n_fail = 0;

  lp_down_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lsclk_stb(lsclk_stb), .subclk_stb(subclk_stb), .chain_unf_in(chain_unf_in),
    .evt_in(evt_in), .irq_unf(irq_unf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : ls_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ls_on) begin ph++; lsclk_stb = (ph % 3 == 0); end
      else lsclk_stb = 1'b0;
    end
  end

  initial begin : sub_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (sub_on) begin ph++; subclk_stb = (ph % 5 == 0); end
      else subclk_stb = 1'b0;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic irq_gap(output int gap);
    int n = 0;
    while (irq_unf !== 1'b1 && n < 4000) begin @(negedge clk); n++; end
    @(negedge clk);
    n = 1;
    while (irq_unf !== 1'b1 && n < 4000) begin @(negedge clk); n++; end
    gap = n;
  endtask

  task automatic halt_clear();
    wr(3'd3, 2'b01, 16'h0004);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), d);
      check("R1 reset readback", d, 16'h0000);
    end
    check("R1 irq idle", {15'd0, irq_unf}, 16'h0000);
  endtask

  task automatic t_lanes();
    logic [15:0] d;
    wr(3'd2, 2'b11, 16'h1234);
    wr(3'd2, 2'b01, 16'h00C8);
    rd(3'd2, d);
    check("R2 low lane write", d, 16'h12C8);
    wr(3'd2, 2'b10, 16'h0000);
    rd(3'd2, d);
    check("R2 high lane write", d, 16'h00C8);
    wr(3'd4, 2'b11, 16'hFFFF);
    rd(3'd4, d);
    check("R2 mode2 kept bits", d, 16'h0087);
    wr(3'd4, 2'b01, 16'h0000);
  endtask

  task automatic t_start_stop();
    logic [15:0] d;
    wr(3'd0, 2'b11, 16'd100);
    wr(3'd3, 2'b01, 16'h0001);
    idle(1);
    rd(3'd3, d);
    check("R3 start and status", d, 16'h0003);
    rd(3'd0, d);
    check("R3 counter moving", {15'd0, (d < 16'd100)}, 16'h0001);
    wr(3'd3, 2'b01, 16'h0004);
    rd(3'd3, d);
    check("R5 stop clears start/status", d, 16'h0000);
    rd(3'd0, d);
    check("R5 stop reloads counter", d, 16'd100);
    idle(5);
    rd(3'd0, d);
    check("R3 no count while stopped", d, 16'd100);
    wr(3'd3, 2'b01, 16'h0005);
    idle(3);
    rd(3'd3, d);
    check("R5 stop wins over start", d, 16'h0000);
  endtask

  task automatic t_period(logic [15:0] m1, logic [15:0] rl, int exp, string req);
    int g;
    halt_clear();
    wr(3'd3, 2'b10, {m1[7:0], 8'h00});
    wr(3'd0, 2'b11, rl);
    wr(3'd3, 2'b01, 16'h0001);
    irq_gap(g);
    check(req, 16'(g), 16'(exp));
  endtask

  task automatic t_compare_flags();
    logic [15:0] d;
    halt_clear();
    wr(3'd3, 2'b10, 16'h0000);
    wr(3'd1, 2'b11, 16'd2);
    wr(3'd0, 2'b11, 16'd7);
    wr(3'd3, 2'b01, 16'h0001);
    idle(20);
    wr(3'd3, 2'b01, 16'h00F4);
    rd(3'd3, d);
    check("R7 A flag set, B flag clear; R4 underflow flag", d, 16'h0060);
    wr(3'd3, 2'b01, 16'h00F0);
    rd(3'd3, d);
    check("R6 writing 1 keeps flags", d, 16'h0060);
    wr(3'd3, 2'b01, 16'h00D0);
    rd(3'd3, d);
    check("R6 writing 0 clears underflow flag only", d, 16'h0040);
    wr(3'd3, 2'b01, 16'h0000);
    rd(3'd3, d);
    check("R6 all flags cleared", d, 16'h0000);
  endtask

  task automatic t_chain();
    logic [15:0] d;
    halt_clear();
    wr(3'd3, 2'b10, 16'h5000);
    wr(3'd0, 2'b11, 16'd2);
    wr(3'd3, 2'b01, 16'h0001);
    idle(2);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); chain_unf_in = 1'b1;
      @(negedge clk); chain_unf_in = 1'b0;
    end
    rd(3'd0, d);
    check("R8 chain strobes counted", d, 16'd0);
    @(negedge clk); chain_unf_in = 1'b1;
    @(negedge clk); chain_unf_in = 1'b0;
    check("R8 chain underflow irq", {15'd0, irq_unf}, 16'h0001);
    rd(3'd0, d);
    check("R4 reload after underflow", d, 16'd2);
  endtask

  task automatic t_event();
    logic [15:0] d;
    halt_clear();
    wr(3'd3, 2'b10, 16'h0200);
    wr(3'd0, 2'b11, 16'd10);
    wr(3'd3, 2'b01, 16'h0001);
    idle(3);
    evt_in = 1'b1; idle(5);
    rd(3'd0, d);
    check("R10 rising edge counted", d, 16'd9);
    evt_in = 1'b0; idle(5);
    rd(3'd0, d);
    check("R10 falling edge ignored", d, 16'd9);
    wr(3'd3, 2'b10, 16'h0A00);
    evt_in = 1'b1; idle(5);
    rd(3'd0, d);
    check("R10 rising ignored in falling mode", d, 16'd9);
    evt_in = 1'b0; idle(5);
    rd(3'd0, d);
    check("R10 falling edge counted", d, 16'd8);
    rd(3'd3, d);
    check("R10 edge flag", d, 16'h0A13);
  endtask

  task automatic t_unsupported();
    logic [15:0] d;
    halt_clear();
    wr(3'd3, 2'b10, 16'h0100);
    wr(3'd0, 2'b11, 16'd5);
    wr(3'd3, 2'b01, 16'h0001);
    idle(20);
    rd(3'd0, d);
    check("R11 counter holds in unbuilt mode", d, 16'd5);
    rd(3'd3, d);
    check("R11 no underflow flag", d, 16'h0103);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lanes();
    t_start_stop();
    t_period(16'h00, 16'd3, 4,  "R4 period N+1 on every clock");
    t_period(16'h30, 16'd3, 8,  "R8 source divide by 2");
    t_period(16'h10, 16'd1, 16, "R8 source divide by 8");
    ls_on = 1'b1;
    wr(3'd4, 2'b01, 16'h0002);
    t_period(16'h40, 16'd1, 24, "R9 low-speed strobe prescale 4");
    ls_on = 1'b0; sub_on = 1'b1;
    wr(3'd4, 2'b01, 16'h0001);
    t_period(16'h60, 16'd1, 20, "R9 subclock prescale 2");
    sub_on = 1'b0;
    wr(3'd4, 2'b01, 16'h0000);
    t_compare_flags();
    t_chain();
    t_event();
    t_unsupported();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule